// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Order

This block generates the address for each beat of a four-beat burst. A load command captures a full start address. Each later advance command moves the two lowest address bits to the next burst position. The bits above them keep the value they were loaded with. A mode input picks one of two orders. In the first, each beat's low bits are the start's low bits XORed with the beat number. In the second, they are the start's low bits plus the beat number, wrapping modulo four.

The controller that issues the burst drives `adv` low with a new address to start a burst. It then drives `adv` high once per following beat. `stall` freezes the sequencer for any number of cycles. The mode input is expected to stay constant while bursts are running. A burst that is advanced past its fourth beat starts over at the loaded start address.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_out` is all zeros.
- R2: On a clock edge with `stall` low and `adv` low, the sequencer captures `addr_in`, and from that edge on `addr_out` equals it.
- R3: With `xor_order` high, `addr_out[1:0]` after k advances since the load equals the start's low bits XOR (k mod 4). Consecutive beats therefore always differ in bit 0.
- R4: With `xor_order` low, `addr_out[1:0]` after k advances since the load equals the start's low bits plus k, modulo 4. Each advance adds one, with wrap.
- R5: An advance (`stall` low, `adv` high) never changes `addr_out[ADDR_W-1:2]`.
- R6: The fifth beat, reached after four advances, is again the loaded start address, and the sequence then repeats.
- R7: While `stall` is high, `addr_out` holds its value, whatever `adv` and `addr_in` do.
- R8: During an advance, the value on `addr_in` has no effect on `addr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall | input | 1 | High: keep all state unchanged this cycle |
| adv | input | 1 | Low: load `addr_in`; high: step to the next burst beat |
| xor_order | input | 1 | High: XOR-interleaved order; low: linear wrapping order (kept static) |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst address |

## Verification
There are two kinds of internal fault to watch for. A wrong beat count or a wrong captured start value shows up in `addr_out[1:0]` one edge after the faulty step. An upper-field fault shows up in the high bits on the first advance after the load. Sweeping every start value in both orders through six beats catches ordering faults and wrap faults within one burst. Placing stall windows and noisy `addr_in` values between beats catches state that moves when it should hold.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } seq_op_e;

    function automatic seq_op_e decode_op(input logic stall, input logic adv);
        if (stall)
            return OP_HOLD;
        else if (adv)
            return OP_STEP;
        else
            return OP_LOAD;
    endfunction

endpackage

// File: rtl/burst_lo_map.sv
module burst_lo_map #(
    parameter int BURST_BITS = 2
) (
    input  logic [BURST_BITS-1:0] start_lo,
    input  logic [BURST_BITS-1:0] beat,
    input  logic                  xor_order,
    output logic [BURST_BITS-1:0] lo_out
);
    logic [BURST_BITS-1:0] xor_lo;
    logic [BURST_BITS-1:0] lin_lo;

    genvar gi;
    generate
        for (gi = 0; gi < BURST_BITS; gi++) begin : g_xor_bit
            assign xor_lo[gi] = start_lo[gi] ^ beat[gi];
        end
    endgenerate

    // Sum truncated to BURST_BITS gives the modulo wrap
    assign lin_lo = start_lo + beat;

    always_comb begin
        lo_out = xor_order ? xor_lo : lin_lo;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int ADDR_W     = 19,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              adv,
    input  logic              xor_order,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    import burst_seq_pkg::*;

    localparam int HI_W = ADDR_W - BURST_BITS;

    typedef struct packed {
        logic [HI_W-1:0]       upper;
        logic [BURST_BITS-1:0] start_lo;
        logic [BURST_BITS-1:0] beat;
    } seq_state_t;

    seq_state_t st_d, st_q;
    seq_op_e    op;
    logic [BURST_BITS-1:0] lo_cur;

    always_comb begin
        op   = decode_op(stall, adv);
        st_d = st_q;
        case (op)
            OP_LOAD: begin
                st_d.upper    = addr_in[ADDR_W-1:BURST_BITS];
                st_d.start_lo = addr_in[BURST_BITS-1:0];
                st_d.beat     = '0;
            end
            OP_STEP: begin
                st_d.beat = st_q.beat + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    burst_lo_map #(.BURST_BITS(BURST_BITS)) u_map (
        .start_lo  (st_q.start_lo),
        .beat      (st_q.beat),
        .xor_order (xor_order),
        .lo_out    (lo_cur)
    );

    assign addr_out = {st_q.upper, lo_cur};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W     = 19,
    parameter int BURST_BITS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              adv,
    input logic              xor_order,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);
    localparam logic [BURST_BITS-1:0] ONE_LO = 1;

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !adv) |=> (addr_out == $past(addr_in)));

    // R5
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv) |=> (addr_out[ADDR_W-1:BURST_BITS] == $past(addr_out[ADDR_W-1:BURST_BITS])));

    // R7
    stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $stable(xor_order)) |=> (!$stable(xor_order) || $stable(addr_out)));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv && !xor_order) |=>
        (xor_order || addr_out[BURST_BITS-1:0] == $past(addr_out[BURST_BITS-1:0]) + ONE_LO));

    // R3
    xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv && xor_order) |=>
        (!xor_order || addr_out[0] != $past(addr_out[0])));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .adv       (adv),
    .xor_order (xor_order),
    .addr_in   (addr_in),
    .addr_out  (addr_out)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic          adv = 1'b0;
    logic          xor_order = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BURST_BITS(2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .adv       (adv),
        .xor_order (xor_order),
        .addr_in   (addr_in),
        .addr_out  (addr_out)
    );

    task automatic check(input string req, input logic [AW-1:0] exp);
        n_run++;
        if (addr_out !== exp) begin
            n_fail++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    task automatic cycle(input logic s, input logic a, input logic [AW-1:0] ai);
        @(negedge clk);
        stall = s; adv = a; addr_in = ai;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [1:0] expect_lo(input logic m, input logic [1:0] st, input int k);
        logic [1:0] kk;
        kk = 2'(k % 4);
        return m ? (st ^ kk) : 2'(st + kk);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [AW-1:0] base;
        logic [AW-3:0] up;
        repeat (3) @(posedge clk);
        #1;
        check("R1", '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int m = 0; m < 2; m++) begin
            for (int u = 0; u < 3; u++) begin
                for (int s = 0; s < 4; s++) begin
                    up = (u == 0) ? '0 : (u == 1) ? '1 : 17'h0A5C3;
                    base = {up, 2'(s)};
                    @(negedge clk);
                    xor_order = m[0];
                    cycle(1'b0, 1'b0, base);
                    check("R2", base);
                    for (int k = 1; k <= 6; k++) begin
                        // noisy addr_in during advance: R8
                        cycle(1'b0, 1'b1, ~base);
                        check(m ? "R3/R5/R6/R8" : "R4/R5/R6/R8",
                              {up, expect_lo(m[0], 2'(s), k)});
                        if (k == 4)
                            check("R6", base);
                        if (k == 2) begin
                            cycle(1'b1, 1'b1, ~base);
                            check("R7", {up, expect_lo(m[0], 2'(s), k)});
                            cycle(1'b1, 1'b0, ~base);
                            check("R7", {up, expect_lo(m[0], 2'(s), k)});
                        end
                    end
                end
            end
        end

        // reload mid-burst restarts the count
        @(negedge clk);
        xor_order = 1'b1;
        cycle(1'b0, 1'b0, 19'h12345);
        cycle(1'b0, 1'b1, '0);
        cycle(1'b0, 1'b0, 19'h00002);
        check("R2", 19'h00002);
        cycle(1'b0, 1'b1, '1);
        check("R3", 19'h00003);

        // asynchronous reset after activity
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", '0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule